// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block turns an active-low interrupt pin from outside the chip into an interrupt request for the core. The pin first passes through a chain of synchronizing flops. It is then either watched as a level or, in edge mode, a falling edge is caught in a sticky latch. The latch holds its state until the interrupt has been serviced or the block is reset. A connect bit can cut the pin off from the request logic completely.

An 8-bit control register holds the two settings and can be read back at any time. In special modes the edge/level select can be rewritten freely. In normal and emulation modes the first register write after reset freezes it, so software cannot change how the pin is recognized later on. The connect bit stays writable in every mode. Priority arbitration and vectoring happen outside this block.

Top module: `extint_ctrl`

## Requirements
- R1: After reset the select bit is 0 (level), the connect bit is 1, no edge is latched, `irq_req` is 0 and the register reads 0x40.
- R2: With select 0 and connect 1, `irq_req` is high exactly while the synchronized pin is low. A pin change reaches `irq_req` after SYNC_STAGES clock edges.
- R3: With select 1 and connect 1, a falling edge on the pin sets the edge latch, and `irq_req` rises SYNC_STAGES+1 clock edges after the pin falls. In this mode a pin that merely stays low raises no new request after the latch has been cleared.
- R4: A set edge latch holds when the pin returns high. A one-cycle `irq_ack` pulse clears it. If a new falling edge is seen in the same cycle as `irq_ack`, the latch stays set.
- R5: While the connect bit is 0, `irq_req` is 0 and no edge is latched. Setting the connect bit again does not raise a request for edges that arrived while it was 0.
- R6: When `mode` is 00 (normal) or 01 (emulation), the first write after reset sets the lock, even if the written value equals the current one. Later writes leave the select bit unchanged, while the connect bit still takes `wr_data[6]`.
- R7: When `mode[1]` is 1 (special), every write loads the select bit from `wr_data[7]`, whatever the state of the lock.
- R8: The readback places the select bit at bit 7 and the connect bit at bit 6. Bits 5..0 always read 0. `rd_data` is 0 while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | 1 | External interrupt pin, active low, asynchronous |
| mode | input | 2 | Operating mode: 00 normal, 01 emulation, 1x special |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Write data: bit 7 select, bit 6 connect |
| rd_en | input | 1 | Control register read strobe |
| rd_data | output | 8 | Register readback, 0 when not reading |
| irq_ack | input | 1 | Interrupt serviced pulse, clears the edge latch |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
The bench builds the block with its default SYNC_STAGES of 2. It derives its latency windows from that value, so the level path is checked at exactly two edges and the edge path at exactly three. With this depth, the cycle in which a new falling edge and an acknowledge meet can be hit exactly from the bench, which makes the set-over-clear ordering observable. Mode changes between special, normal and emulation within one reset window bring the lock's first-write and bypass behaviour within reach.

// File: rtl/extint_pkg.sv
package extint_pkg;

  localparam int CTL_W   = 8;
  localparam int SEL_POS = 7;
  localparam int CON_POS = 6;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_EMUL    = 2'b01,
    MODE_SPECIAL = 2'b10,
    MODE_SPEC_B  = 2'b11
  } op_mode_e;

  // special modes are those with the upper mode bit set
  function automatic logic mode_is_special(input logic [1:0] m);
    return m[1];
  endfunction

  // falling edge between the previous and the current synchronized level
  function automatic logic fall_between(input logic prev_lvl, input logic cur_lvl);
    return prev_lvl & ~cur_lvl;
  endfunction

  // request: level mode looks at the pin, edge mode at the latch
  function automatic logic request_of(input logic sel_edge, input logic connect,
                                      input logic latched, input logic pin_lvl);
    return connect & (sel_edge ? latched : ~pin_lvl);
  endfunction

  // next latch state: new edge has priority over an acknowledge
  function automatic logic latch_next(input logic cur, input logic set_ev,
                                      input logic clr_ev);
    return (cur & ~clr_ev) | set_ev;
  endfunction

  function automatic logic [CTL_W-1:0] pack_ctl(input logic sel_edge, input logic connect);
    logic [CTL_W-1:0] v;
    v = '0;
    v[SEL_POS] = sel_edge;
    v[CON_POS] = connect;
    return v;
  endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= RST_VAL;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/extint_cfg.sv
module extint_cfg
  import extint_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic       wr_con,
  output logic       sel_edge,
  output logic       connect,
  output logic       locked,
  output logic       sel_load
);

  logic special;

  assign special  = mode_is_special(mode);
  assign sel_load = wr_en & (special | ~locked);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_edge <= 1'b0;
      connect  <= 1'b1;
      locked   <= 1'b0;
    end else begin
      if (wr_en) connect <= wr_con;
      if (sel_load) sel_edge <= wr_sel;
      if (wr_en && !special) locked <= 1'b1;
    end
  end

endmodule

// File: rtl/extint_detect.sv
module extint_detect
  import extint_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_lvl,
  input  logic sel_edge,
  input  logic connect,
  input  logic ack,
  output logic fall,
  output logic set_ev,
  output logic latched,
  output logic req
);

  logic pin_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_prev <= 1'b1;
    else        pin_prev <= pin_lvl;
  end

  assign fall   = fall_between(pin_prev, pin_lvl);
  assign set_ev = fall & sel_edge & connect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latched <= 1'b0;
    else        latched <= latch_next(latched, set_ev, ack);
  end

  assign req = request_of(sel_edge, connect, latched, pin_lvl);

endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_n,
  input  logic [1:0]       mode,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [CTL_W-1:0] rd_data,
  input  logic             irq_ack,
  output logic             irq_req
);

  logic pin_lvl;
  logic sel_edge;
  logic connect;
  logic locked;
  logic sel_load;
  logic fall;
  logic set_ev;
  logic latched;
  logic unused_wr_bits;

  assign unused_wr_bits = ^wr_data[CON_POS-1:0];

  extint_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_n),
    .q     (pin_lvl)
  );

  extint_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .wr_en    (wr_en),
    .wr_sel   (wr_data[SEL_POS]),
    .wr_con   (wr_data[CON_POS]),
    .sel_edge (sel_edge),
    .connect  (connect),
    .locked   (locked),
    .sel_load (sel_load)
  );

  extint_detect u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_lvl  (pin_lvl),
    .sel_edge (sel_edge),
    .connect  (connect),
    .ack      (irq_ack),
    .fall     (fall),
    .set_ev   (set_ev),
    .latched  (latched),
    .req      (irq_req)
  );

  assign rd_data = rd_en ? pack_ctl(sel_edge, connect) : '0;

endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk
  import extint_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             wr_en,
  input logic [CTL_W-1:0] wr_data,
  input logic             rd_en,
  input logic [CTL_W-1:0] rd_data,
  input logic             irq_ack,
  input logic             irq_req,
  input logic             pin_lvl,
  input logic             sel_edge,
  input logic             connect,
  input logic             locked,
  input logic             fall,
  input logic             set_ev,
  input logic             latched
);

  p_level_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (connect && !sel_edge && !pin_lvl) |-> irq_req);

  p_edge_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (connect && sel_edge && fall) |=> latched);

  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !irq_ack) |=> latched);

  p_ack_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !set_ev) |=> !latched);

  p_disc_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !connect |-> !irq_req);

  p_disc_no_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!connect && !latched) |=> !latched);

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_en && !mode_is_special(mode)) |=> (sel_edge == $past(sel_edge)));

  p_special_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode_is_special(mode)) |=> (sel_edge == $past(wr_data[SEL_POS])));

  always_comb begin
    if (rst_n) begin
      p_rd_zero_bits_r8: assert (rd_data[CON_POS-1:0] == '0);
      p_rd_idle_r8: assert (rd_en || rd_data == '0);
    end
  end

endmodule

bind extint_ctrl extint_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (mode),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .irq_ack  (irq_ack),
  .irq_req  (irq_req),
  .pin_lvl  (pin_lvl),
  .sel_edge (sel_edge),
  .connect  (connect),
  .locked   (locked),
  .fall     (fall),
  .set_ev   (set_ev),
  .latched  (latched)
);

// File: tb/tb_extint_ctrl.sv
module tb_extint_ctrl;

  localparam int SYNC_STAGES = 2;
  localparam int LVL_LAT     = SYNC_STAGES;
  localparam int EDGE_LAT    = SYNC_STAGES + 1;
  localparam int SETTLE      = EDGE_LAT + 1;
  localparam int NVEC        = 23;

  // vector: mode[21:20] wr[19] wdata[18:11] pin_n[10] ack[9] exp_req[8] exp_rd[7:0]
  localparam logic [21:0] VEC [NVEC] = '{
    {2'b00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h40},  // 0  R1 idle after reset
    {2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h40},  // 1  R2 level low
    {2'b00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h40},  // 2  R2 level high
    {2'b10, 1'b1, 8'hC0, 1'b1, 1'b0, 1'b0, 8'hC0},  // 3  R7 special write edge mode
    {2'b10, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'hC0},  // 4  R3 falling edge
    {2'b10, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'hC0},  // 5  R4 held after pin high
    {2'b10, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'hC0},  // 6  R4 ack clears
    {2'b10, 1'b1, 8'h80, 1'b1, 1'b0, 1'b0, 8'h80},  // 7  R5 disconnect
    {2'b10, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h80},  // 8  R5 edge ignored
    {2'b10, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h80},  // 9  R5
    {2'b10, 1'b1, 8'hC0, 1'b1, 1'b0, 1'b0, 8'hC0},  // 10 R5 reconnect, nothing pending
    {2'b10, 1'b1, 8'h40, 1'b1, 1'b0, 1'b0, 8'h40},  // 11 R7 back to level
    {2'b00, 1'b1, 8'hC0, 1'b1, 1'b0, 1'b0, 8'hC0},  // 12 R6 first normal write
    {2'b00, 1'b1, 8'h40, 1'b1, 1'b0, 1'b0, 8'hC0},  // 13 R6 select frozen
    {2'b00, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 8'h80},  // 14 R6 connect still writable
    {2'b00, 1'b1, 8'h40, 1'b1, 1'b0, 1'b0, 8'hC0},  // 15 R6
    {2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'hC0},  // 16 R3 edge in normal
    {2'b00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'hC0},  // 17 R4 ack, pin still low
    {2'b00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'hC0},  // 18 R3
    {2'b01, 1'b1, 8'h40, 1'b1, 1'b0, 1'b0, 8'hC0},  // 19 R6 emulation locked too
    {2'b10, 1'b1, 8'h40, 1'b1, 1'b0, 1'b0, 8'h40},  // 20 R7 special bypasses lock
    {2'b10, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h40},  // 21 R2
    {2'b10, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h40}   // 22 R2
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_n = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       irq_ack = 1'b0;
  logic       irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  extint_ctrl #(.SYNC_STAGES(SYNC_STAGES)) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_n   (pin_n),
    .mode    (mode),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .irq_ack (irq_ack),
    .irq_req (irq_req)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pin_n = 1'b1; wr_en = 1'b0; irq_ack = 1'b0; rd_en = 1'b0;
    mode = 2'b00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_reg(input logic [1:0] m, input logic [7:0] d);
    mode = m; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_check(input string tag, input logic [7:0] exp);
    rd_en = 1'b1;
    #1 check(tag, rd_data, exp);
    rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 req after reset", {7'd0, irq_req}, 8'h00);
    read_check("R1 readback after reset", 8'h40);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      mode    = VEC[i][21:20];
      wr_en   = VEC[i][19];
      wr_data = VEC[i][18:11];
      pin_n   = VEC[i][10];
      irq_ack = VEC[i][9];
      @(negedge clk);
      wr_en = 1'b0; irq_ack = 1'b0;
      settle();
      check($sformatf("vec %0d req (R2 R3 R4 R5)", i), {7'd0, irq_req}, {7'd0, VEC[i][8]});
      read_check($sformatf("vec %0d readback (R6 R7 R8)", i), VEC[i][7:0]);
    end

    // R2 level latency
    do_reset();
    pin_n = 1'b0;
    repeat (LVL_LAT - 1) @(negedge clk);
    check("R2 level not yet", {7'd0, irq_req}, 8'h00);
    @(negedge clk);
    check("R2 level at latency", {7'd0, irq_req}, 8'h01);
    pin_n = 1'b1;
    repeat (LVL_LAT) @(negedge clk);
    check("R2 level release", {7'd0, irq_req}, 8'h00);

    // R3 edge latency, R4 coincident ack and edge
    do_reset();
    write_reg(2'b10, 8'hC0);
    settle();
    pin_n = 1'b0;
    repeat (EDGE_LAT - 1) @(negedge clk);
    check("R3 edge not yet", {7'd0, irq_req}, 8'h00);
    @(negedge clk);
    check("R3 edge at latency", {7'd0, irq_req}, 8'h01);
    pin_n = 1'b1;
    settle();
    check("R4 latch held", {7'd0, irq_req}, 8'h01);
    pin_n = 1'b0;
    repeat (EDGE_LAT - 1) @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check("R4 edge beats ack", {7'd0, irq_req}, 8'h01);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check("R4 ack clears", {7'd0, irq_req}, 8'h00);
    settle();
    check("R3 low pin no new request", {7'd0, irq_req}, 8'h00);

    // R1 reset clears a pending latch
    pin_n = 1'b1;
    settle();
    pin_n = 1'b0;
    settle();
    pin_n = 1'b1;
    settle();
    check("R4 pending before reset", {7'd0, irq_req}, 8'h01);
    do_reset();
    check("R1 reset clears latch", {7'd0, irq_req}, 8'h00);
    read_check("R1 reset restores register", 8'h40);

    // R6 lock on a same-value write
    write_reg(2'b00, 8'h40);
    write_reg(2'b00, 8'hC0);
    read_check("R6 same-value write locks", 8'h40);

    // R8 readback gated by rd_en, ignores low write bits
    write_reg(2'b00, 8'h3F);
    rd_en = 1'b0;
    #1 check("R8 idle readback zero", rd_data, 8'h00);
    read_check("R8 low bits read zero", 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule